// File: doc/BRIEF.md
# Four-Lane 7:1 Serial Transmitter

This block turns a 28-bit parallel word into five serial streams. The word arrives once per period of a slow word clock. Each word is split into four 7-bit slices, and each slice goes out on its own data lane, one bit per cycle of a bit clock that runs seven times faster. A fifth lane carries a copy of the word clock built from a fixed seven-slot pattern. It shares the framing of the data lanes, so a matching receiver can find the frame boundaries from it.

The block does not generate the fast clock. It takes the bit clock as given, together with a one-cycle frame strobe that marks the bit-clock edge at which a new frame is loaded. A static select input chooses which edge of the word clock captures the input word. An active-low shutdown input clears every register and holds all five outputs low. The word capture is double-buffered: while one word is being shifted out, the capture register is already free to take the next one. After shutdown is released, no clock and no data leave the block until a word has been captured and then loaded at a frame boundary.

Top module: `lvtx_serializer`

## Requirements
- R1: Data lane k sends input bits 7k to 7k+6. Within a frame, slot j of lane k is bit 7k+j, so the lowest-numbered bit goes first.
- R2: A frame is loaded at a bit-clock rising edge where frame_strobe is sampled high. Slot j is driven during the j-th bit-clock cycle after that edge (j = 0..6).
- R3: In every frame that carries a word, the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6. In any other frame it stays low.
- R4: With edge_rise = 1, the word present at a rising edge of word_clk is sent in the frame loaded at the next strobe.
- R5: With edge_rise = 0, the word present at a falling edge of word_clk is sent in the frame loaded at the next strobe.
- R6: While shutdown_n is low, all five serial outputs are low at once, with no clock edge needed. All registers are cleared at each bit-clock and word-clock edge.
- R7: After shutdown_n returns high, every frame loaded before the first word capture is all-zero on all five lanes, including the clock lane.
- R8: The next word can be captured while the current frame is still shifting. Consecutive frames then carry consecutive captured words, with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, seven times the word clock |
| word_clk | input | 1 | Word clock; one input word per period |
| frame_strobe | input | 1 | High for one bit-clock cycle; marks the frame load edge |
| shutdown_n | input | 1 | Active-low shutdown and clear |
| edge_rise | input | 1 | 1: capture on rising word_clk edge, 0: on falling edge |
| par_data | input | 28 | Parallel input word |
| lane_ser | output | 4 | Serial data lanes; bit k is lane k |
| clk_ser | output | 1 | Forwarded clock lane |

## Verification
On every bit-clock cycle, the bound checker tracks the slot position within the frame. It confirms that the clock lane follows its seven-slot pattern or stays low for a whole frame, that the data lanes stay silent in any frame without a clock, and that all outputs are low during shutdown. Other properties can only be shown by the bench's scenarios, which deserialize every frame and compare it with the words applied: the mapping of input bits to lanes and slots, which word-clock edge captures data, the extra frame of latency in rising-edge mode, and the loss-free hand-off between capture and shifting.

// File: rtl/lvtx_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the four-lane serial transmitter.
// Assumes frames are SLICE_W bit-clock cycles long.
package lvtx_pkg;
    localparam int DEF_LANES   = 4;
    localparam int DEF_SLICE_W = 7;
    // Forwarded clock lane pattern, slot 0 in bit 0 (must start with a 1).
    localparam logic [DEF_SLICE_W-1:0] DEF_CLK_PAT = 7'b1100011;

    typedef enum logic {
        CAP_FALL = 1'b0,
        CAP_RISE = 1'b1
    } cap_edge_e;
endpackage

// File: rtl/lvtx_capture.sv
`timescale 1ns/1ps
// Module: word capture on either edge of the word clock.
// Holds one register per edge. edge_rise is static and picks which one is used.
// Assumes edge_rise changes only while shutdown is asserted.
module lvtx_capture #(
    parameter int WORD_W = 28
) (
    input  logic              word_clk,
    input  logic              shutdown_n,
    input  logic              edge_rise,
    input  logic [WORD_W-1:0] par_data,
    output logic [WORD_W-1:0] cap_word,
    output logic              cap_valid
);
    import lvtx_pkg::*;

    logic [WORD_W-1:0] rise_word, fall_word;
    logic              rise_vld, fall_vld;
    cap_edge_e         sel;

    // Rising-edge capture register with synchronous clear.
    always_ff @(posedge word_clk) begin
        if (!shutdown_n) begin
            rise_word <= '0;
            rise_vld  <= 1'b0;
        end else begin
            rise_word <= par_data;
            rise_vld  <= 1'b1;
        end
    end

    // Falling-edge capture register with synchronous clear.
    always_ff @(negedge word_clk) begin
        if (!shutdown_n) begin
            fall_word <= '0;
            fall_vld  <= 1'b0;
        end else begin
            fall_word <= par_data;
            fall_vld  <= 1'b1;
        end
    end

    // Select the register belonging to the chosen edge.
    always_comb begin
        sel = cap_edge_e'(edge_rise);
        if (sel == CAP_RISE) begin
            cap_word  = rise_word;
            cap_valid = rise_vld;
        end else begin
            cap_word  = fall_word;
            cap_valid = fall_vld;
        end
    end
endmodule

// File: rtl/lvtx_framer.sv
`timescale 1ns/1ps
// Module: builds the per-lane load values for one frame.
// Slices the captured word into lanes and adds the clock pattern.
// If no word has been captured, every load value is zero.
module lvtx_framer #(
    parameter int                 LANES       = 4,
    parameter int                 SLICE_W     = 7,
    parameter logic [SLICE_W-1:0] CLK_PATTERN = 7'b1100011,
    localparam int                WORD_W      = LANES * SLICE_W
) (
    input  logic [WORD_W-1:0]  cap_word,
    input  logic               cap_valid,
    output logic [WORD_W-1:0]  data_load,
    output logic [SLICE_W-1:0] clk_load
);
    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_slice
            // Lane k takes bits k*SLICE_W upward, gated by capture validity.
            always_comb begin
                data_load[k*SLICE_W +: SLICE_W] =
                    cap_valid ? cap_word[k*SLICE_W +: SLICE_W] : '0;
            end
        end
    endgenerate

    // Clock lane pattern only for frames that carry a word.
    always_comb begin
        clk_load = cap_valid ? CLK_PATTERN : '0;
    end
endmodule

// File: rtl/lvtx_lane.sv
`timescale 1ns/1ps
// Module: one serial lane, a parallel-load right shift register.
// Loads on the strobe edge and then sends bit 0 first.
// The output is forced low while shutdown is asserted.
module lvtx_lane #(
    parameter int SLICE_W = 7
) (
    input  logic               bit_clk,
    input  logic               shutdown_n,
    input  logic               load,
    input  logic [SLICE_W-1:0] load_val,
    output logic               ser_out
);
    logic [SLICE_W-1:0] shreg;

    // Load a new slice on the frame edge, otherwise shift one place.
    always_ff @(posedge bit_clk) begin
        if (!shutdown_n)
            shreg <= '0;
        else if (load)
            shreg <= load_val;
        else
            shreg <= {1'b0, shreg[SLICE_W-1:1]};
    end

    // Gate the output so shutdown takes effect without waiting for an edge.
    always_comb begin
        ser_out = shreg[0] & shutdown_n;
    end
endmodule

// File: rtl/lvtx_serializer.sv
`timescale 1ns/1ps
// Module: four-lane 7:1 serializer with a forwarded clock lane (top).
// Captures a word on the selected word_clk edge and loads all lanes at
// frame_strobe. Assumes the strobe comes every SLICE_W bit-clock cycles and
// falls well clear of the capture edge.
module lvtx_serializer #(
    parameter int                 LANES       = lvtx_pkg::DEF_LANES,
    parameter int                 SLICE_W     = lvtx_pkg::DEF_SLICE_W,
    parameter logic [SLICE_W-1:0] CLK_PATTERN = lvtx_pkg::DEF_CLK_PAT
) (
    input  logic                       bit_clk,
    input  logic                       word_clk,
    input  logic                       frame_strobe,
    input  logic                       shutdown_n,
    input  logic                       edge_rise,
    input  logic [LANES*SLICE_W-1:0]   par_data,
    output logic [LANES-1:0]           lane_ser,
    output logic                       clk_ser
);
    localparam int WORD_W = LANES * SLICE_W;

    logic [WORD_W-1:0]  cap_word;
    logic               cap_valid;
    logic [WORD_W-1:0]  data_load;
    logic [SLICE_W-1:0] clk_load;

    lvtx_capture #(.WORD_W(WORD_W)) u_capture (
        .word_clk  (word_clk),
        .shutdown_n(shutdown_n),
        .edge_rise (edge_rise),
        .par_data  (par_data),
        .cap_word  (cap_word),
        .cap_valid (cap_valid)
    );

    lvtx_framer #(.LANES(LANES), .SLICE_W(SLICE_W), .CLK_PATTERN(CLK_PATTERN)) u_framer (
        .cap_word (cap_word),
        .cap_valid(cap_valid),
        .data_load(data_load),
        .clk_load (clk_load)
    );

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            lvtx_lane #(.SLICE_W(SLICE_W)) u_lane (
                .bit_clk   (bit_clk),
                .shutdown_n(shutdown_n),
                .load      (frame_strobe),
                .load_val  (data_load[k*SLICE_W +: SLICE_W]),
                .ser_out   (lane_ser[k])
            );
        end
    endgenerate

    lvtx_lane #(.SLICE_W(SLICE_W)) u_clk_lane (
        .bit_clk   (bit_clk),
        .shutdown_n(shutdown_n),
        .load      (frame_strobe),
        .load_val  (clk_load),
        .ser_out   (clk_ser)
    );
endmodule

// File: rtl/lvtx_checker.sv
`timescale 1ns/1ps
// Module: protocol checker for lvtx_serializer, watching its ports.
// Counts the slot within each frame from frame_strobe. It notes at slot 0
// whether the frame carries a clock.
module lvtx_checker #(
    parameter int                 LANES       = 4,
    parameter int                 SLICE_W     = 7,
    parameter logic [SLICE_W-1:0] CLK_PATTERN = 7'b1100011
) (
    input logic             bit_clk,
    input logic             shutdown_n,
    input logic             frame_strobe,
    input logic [LANES-1:0] lane_ser,
    input logic             clk_ser
);
    localparam int SW = $clog2(SLICE_W + 1);

    logic [SW-1:0]    slot;
    logic             frame_live;
    logic [SLICE_W:0] pat_ext;
    logic             pat_bit;
    logic             in_frame;

    // Slot counter: 0 after a load edge, saturates at SLICE_W when idle.
    always_ff @(posedge bit_clk) begin
        if (!shutdown_n)
            slot <= SW'(SLICE_W);
        else if (frame_strobe)
            slot <= '0;
        else if (slot != SW'(SLICE_W))
            slot <= slot + 1'b1;
    end

    // Note at slot 0 whether this frame carries the clock.
    always_ff @(posedge bit_clk) begin
        if (!shutdown_n)
            frame_live <= 1'b0;
        else if (slot == '0)
            frame_live <= clk_ser;
    end

    // Pattern bit expected at the current slot (0 outside a frame).
    always_comb begin
        pat_ext  = {1'b0, CLK_PATTERN};
        pat_bit  = pat_ext[slot];
        in_frame = (slot != '0) && (slot < SW'(SLICE_W));
    end

    // Outputs are quiet during shutdown.
    always @(posedge bit_clk) begin
        if (!shutdown_n)
            AST_SHDN_QUIET: assert (lane_ser == '0 && !clk_ser); // R6
    end

    AST_CLK_ONLY_IN_PATTERN: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        clk_ser |-> pat_bit); // R3

    AST_CLK_WHOLE_FRAME: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        in_frame |-> (clk_ser == (frame_live & pat_bit))); // R3

    AST_NO_DATA_WITHOUT_CLK: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        ((slot == '0 && !clk_ser) || (in_frame && !frame_live)) |-> (lane_ser == '0)); // R7
endmodule

bind lvtx_serializer lvtx_checker #(
    .LANES(LANES), .SLICE_W(SLICE_W), .CLK_PATTERN(CLK_PATTERN)
) u_lvtx_checker (
    .bit_clk     (bit_clk),
    .shutdown_n  (shutdown_n),
    .frame_strobe(frame_strobe),
    .lane_ser    (lane_ser),
    .clk_ser     (clk_ser)
);

// File: tb/lvtx_serializer_bench.sv
`timescale 1ns/1ps
// Bench: drives words on a 140 ns word clock against a 20 ns bit clock,
// deserializes all lanes and compares frames with expected words.
module lvtx_serializer_bench;
    logic        bit_clk = 1'b0;
    logic        word_clk = 1'b0;
    logic        frame_strobe = 1'b0;
    logic        shutdown_n = 1'b0;
    logic        edge_rise = 1'b1;
    logic [27:0] par_data = '0;
    logic [3:0]  lane_ser;
    logic        clk_ser;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    localparam logic [27:0] VEC [8] = '{
        28'h0000001, 28'h8000000, 28'hFFFFFFF, 28'h0000000,
        28'h5555555, 28'hAAAAAAA, 28'h1234567, 28'h7F00081
    };
    localparam logic [6:0] CLK_EXP = 7'b1100011;

    lvtx_serializer u_lvtx_serializer (
        .bit_clk     (bit_clk),
        .word_clk    (word_clk),
        .frame_strobe(frame_strobe),
        .shutdown_n  (shutdown_n),
        .edge_rise   (edge_rise),
        .par_data    (par_data),
        .lane_ser    (lane_ser),
        .clk_ser     (clk_ser)
    );

    // 50 MHz bit clock: rising edges at 10 + 20n.
    always #10 bit_clk = ~bit_clk;

    // Word clock: rising at 140m+5, falling at 140m+75.
    initial begin
        #5;
        forever begin
            word_clk = 1'b1; #70;
            word_clk = 1'b0; #70;
        end
    end

    // Strobe generation and deserializer; frame f loads at rising edge 7f+6.
    int          k = 0;
    int          fc = 0;
    logic [27:0] acc_w;
    logic [6:0]  acc_c;
    logic [27:0] fr_w [32];
    logic [6:0]  fr_c [32];
    always @(negedge bit_clk) begin
        int j;
        j = (k + 1) % 7;
        if (k >= 6) begin
            for (int ln = 0; ln < 4; ln++) acc_w[7*ln + j] = lane_ser[ln];
            acc_c[j] = clk_ser;
            if (j == 6 && fc < 32) begin
                fr_w[fc] = acc_w;
                fr_c[fc] = acc_c;
                fc++;
            end
        end
        frame_strobe = (((k + 1) % 7) == 6);
        k++;
    end

    task automatic wait_until(input longint t);
        #(t - $time);
    endtask

    task automatic check_frame(input int f, input logic [27:0] ew, input logic [6:0] ec, input string req);
        tests++;
        if (fr_w[f] !== ew) begin
            fails++;
            $display("FAIL %s frame %0d data: got %h expected %h", req, f, fr_w[f], ew);
        end
        tests++;
        if (fr_c[f] !== ec) begin
            fails++;
            $display("FAIL %s frame %0d clock lane: got %b expected %b", req, f, fr_c[f], ec);
        end
    endtask

    initial begin
        // Rising-edge mode, released at 180 ns.
        #100;
        tests++;
        if (lane_ser !== 4'b0 || clk_ser !== 1'b0) begin
            fails++;
            $display("FAIL R6 reset state: got %b/%b expected 0000/0", lane_ser, clk_ser);
        end
        wait_until(180);
        shutdown_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_until(140*(1+i) + 40);
            par_data = VEC[i];
        end
        // Shutdown, change to falling-edge mode, release at 1860 ns.
        wait_until(1580);
        shutdown_n = 1'b0;
        edge_rise  = 1'b0;
        par_data   = 28'h0F0F0F0;
        wait_until(1860);
        shutdown_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_until(140*(13+i) + 40);
            par_data = ~VEC[i];
        end
        // Shutdown in the middle of a frame: outputs must drop at once.
        wait_until(3120);
        shutdown_n = 1'b0;
        #1;
        tests++;
        if (lane_ser !== 4'b0 || clk_ser !== 1'b0) begin
            fails++;
            $display("FAIL R6 immediate quiet: got %b/%b expected 0000/0", lane_ser, clk_ser);
        end
        wait (fc >= 24);
        #1;

        check_frame(0, '0, '0, "R6");
        check_frame(1, '0, '0, "R7 rising");
        for (int i = 0; i < 8; i++)
            check_frame(2 + i, VEC[i], CLK_EXP, "R1 R2 R3 R4 R8");
        check_frame(11, '0, '0, "R6");
        check_frame(12, '0, '0, "R6 R7");
        for (int i = 0; i < 8; i++)
            check_frame(13 + i, ~VEC[i], CLK_EXP, "R1 R2 R3 R5 R8");
        check_frame(22, '0, '0, "R6");
        check_frame(23, '0, '0, "R6");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #20000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule